// File: doc/BRIEF.md
# Serial-Controlled Stereo Audio Settings Bank

This block is the control front end of a stereo audio processor. It listens on a two-wire serial bus as a write-only target with one fixed address. It turns the bytes it receives into a set of latched setting codes that the analog part of the chip consumes: master volume, four speaker attenuators with mute flags, an input selector with input gain and a loudness switch, and bass and treble tone codes. The bus lines reach the block as raw pin levels. The block brings them into a fast system clock through synchronizers and finds bus events by edge detection. It acknowledges by pulling its SDA output low.

A transfer begins with a START and an address byte. Any number of data bytes can follow it. Each data byte is routed to one setting by the prefix in its top bits, and the prefixes differ in length. A setting changes only when all eight bits of its byte have arrived. A START seen at any point, even in the middle of a byte, discards the partial byte and waits for a new address. A STOP ends the transfer. After a STOP, or after an address that does not match, the block ignores all bus traffic until the next START.

Top module: `audioCtlRegs`

## Requirements
- R1: After reset, all four speaker fields hold 11111, so every mute flag is 1. Volume is 111111, bass and treble are 1111, the input selector is 00, input gain is 11 and loudness is off. The SDA pull-down is released.
- R2: The only address the block acknowledges is 0x88, and its final (direction) bit must be 0. A START is SDA falling while SCL is high. The acknowledge drives `sdaPullLow` high throughout the ninth SCL high phase.
- R3: An address byte other than 0x88, including the read form 0x89, gets no acknowledge. Every later byte is then ignored, with no acknowledge and no setting change, until the next START.
- R4: After a matched address, an unlimited number of data bytes can be sent, and each one is acknowledged. Once a STOP (SDA rising while SCL is high) has been seen, bytes clocked in without a new START get no acknowledge and change nothing.
- R5: A byte with bits 7:6 = 00 loads bits 5:0 into `volumeCode`. Bits 5:3 are the 10 dB steps and bits 2:0 are the 1.25 dB steps.
- R6: A byte with bit 7 = 1 loads bits 4:0 into one speaker field, and no other speaker field changes. Bits 6:5 pick the speaker: 00 left-front, 01 right-front, 10 left-rear, 11 right-rear.
- R7: Each speaker's mute flag is 1 exactly when that speaker's field is 11111.
- R8: A byte with bits 7:5 = 010 loads three fields. Bits 4:3 go to `inputGain`. Bits 1:0 go to `inputSel`. `loudnessOn` is set to the inverse of bit 2.
- R9: A byte with bits 7:4 = 0110 loads bits 3:0 into `bassCode`. A byte with bits 7:4 = 0111 loads bits 3:0 into `trebleCode`.
- R10: A START that arrives part way through a byte discards the bits already received. No setting changes, and address reception starts again.
- R11: `sdaPullLow` is asserted and released only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock pin level |
| sdaIn | input | 1 | Bus data pin level |
| sdaPullLow | output | 1 | 1 pulls SDA low for acknowledge |
| volumeCode | output | 6 | Volume code, coarse bits 5:3, fine bits 2:0 |
| attLf | output | 5 | Left-front attenuator code |
| attRf | output | 5 | Right-front attenuator code |
| attLr | output | 5 | Left-rear attenuator code |
| attRr | output | 5 | Right-rear attenuator code |
| muteLf | output | 1 | Left-front muted |
| muteRf | output | 1 | Right-front muted |
| muteLr | output | 1 | Left-rear muted |
| muteRr | output | 1 | Right-rear muted |
| inputSel | output | 2 | Stereo input number minus one |
| inputGain | output | 2 | Input gain code, 00 highest, 11 is 0 dB |
| loudnessOn | output | 1 | Loudness enabled |
| bassCode | output | 4 | Bass code, bit 3 is the sign |
| trebleCode | output | 4 | Treble code, bit 3 is the sign |

## Verification
A bus edge takes two synchronizer flops to reach the block and one more cycle to be detected. A data byte's strobe therefore appears three cycles after the SCL rise of its eighth bit, and the setting register changes on the cycle after that. The pull-down changes three cycles after the SCL fall that triggers it. The bench holds each SCL phase for six or more system cycles. It reads the acknowledge in the middle of the ninth high phase, and it compares every setting only after the full byte and its acknowledge clock have finished, which is far past the four-cycle register latency.

// File: rtl/audioCtlPkg.sv
package audioCtlPkg;
  localparam int BYTE_W  = 8;
  localparam int VOL_W   = 6;
  localparam int ATT_W   = 5;
  localparam int TONE_W  = 4;
  localparam int NUM_SPK = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_WAITFALL, ST_ACKLO, ST_ACKHI
  } rxState_t;

  typedef struct packed {
    logic              byteStrobe;
    logic [BYTE_W-1:0] byteData;
  } ctlStrobes_t;
endpackage

// File: rtl/busRxCtl.sv
module busRxCtl
  import audioCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h88
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output ctlStrobes_t strobes,
  output logic        sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclQ, sdaQ;
  logic startSeen, stopSeen, sclRise, sclFall;
  rxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaS;
  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign nextByte  = {shiftReg[BYTE_W-2:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state              <= ST_IDLE;
      bitCnt             <= '0;
      shiftReg           <= '0;
      strobes.byteStrobe <= 1'b0;
      strobes.byteData   <= '0;
    end else begin
      strobes.byteStrobe <= 1'b0;
      if (startSeen) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (sclRise) begin
              shiftReg <= nextByte;
              bitCnt   <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) begin
                if (state == ST_ADDR) begin
                  state <= (nextByte == DEV_ADDR) ? ST_WAITFALL : ST_IDLE;
                end else begin
                  strobes.byteStrobe <= 1'b1;
                  strobes.byteData   <= nextByte;
                  state              <= ST_WAITFALL;
                end
              end
            end
          end
          ST_WAITFALL: if (sclFall) state <= ST_ACKLO;
          ST_ACKLO:    if (sclRise) state <= ST_ACKHI;
          ST_ACKHI: begin
            if (sclFall) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdaPullLow = (state == ST_ACKLO) || (state == ST_ACKHI);
endmodule

// File: rtl/settingsDatapath.sv
module settingsDatapath
  import audioCtlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  output logic [VOL_W-1:0]   volumeCode,
  output logic [ATT_W-1:0]   attArr [NUM_SPK],
  output logic [NUM_SPK-1:0] muteArr,
  output logic [SEL_W-1:0]   inputSel,
  output logic [SEL_W-1:0]   inputGain,
  output logic               loudnessOn,
  output logic [TONE_W-1:0]  bassCode,
  output logic [TONE_W-1:0]  trebleCode
);
  logic [BYTE_W-1:0] b;
  logic hitVol, hitSpk, hitSwitch, hitBass, hitTreble;

  assign b         = strobes.byteData;
  assign hitVol    = strobes.byteStrobe && (b[7:6] == 2'b00);
  assign hitSpk    = strobes.byteStrobe && b[7];
  assign hitSwitch = strobes.byteStrobe && (b[7:5] == 3'b010);
  assign hitBass   = strobes.byteStrobe && (b[7:4] == 4'b0110);
  assign hitTreble = strobes.byteStrobe && (b[7:4] == 4'b0111);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volumeCode <= '1;
      inputSel   <= '0;
      inputGain  <= '1;
      loudnessOn <= 1'b0;
      bassCode   <= '1;
      trebleCode <= '1;
    end else begin
      if (hitVol) volumeCode <= b[VOL_W-1:0];
      if (hitSwitch) begin
        inputGain  <= b[4:3];
        loudnessOn <= ~b[2];
        inputSel   <= b[1:0];
      end
      if (hitBass)   bassCode   <= b[TONE_W-1:0];
      if (hitTreble) trebleCode <= b[TONE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SPK; g++) begin : gSpk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) attArr[g] <= '1;
      else if (hitSpk && (b[6:5] == 2'(g))) attArr[g] <= b[ATT_W-1:0];
    end
    assign muteArr[g] = &attArr[g];
  end
endmodule

// File: rtl/audioCtlRegs.sv
module audioCtlRegs
  import audioCtlPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR = 8'h88
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic [5:0] volumeCode,
  output logic [4:0] attLf,
  output logic [4:0] attRf,
  output logic [4:0] attLr,
  output logic [4:0] attRr,
  output logic       muteLf,
  output logic       muteRf,
  output logic       muteLr,
  output logic       muteRr,
  output logic [1:0] inputSel,
  output logic [1:0] inputGain,
  output logic       loudnessOn,
  output logic [3:0] bassCode,
  output logic [3:0] trebleCode
);
  ctlStrobes_t strobes;
  logic [ATT_W-1:0] attArr [NUM_SPK];
  logic [NUM_SPK-1:0] muteArr;

  busRxCtl #(.SYNC_STAGES(SYNC_STAGES), .DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobes(strobes), .sdaPullLow(sdaPullLow)
  );

  settingsDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .volumeCode(volumeCode), .attArr(attArr), .muteArr(muteArr),
    .inputSel(inputSel), .inputGain(inputGain), .loudnessOn(loudnessOn),
    .bassCode(bassCode), .trebleCode(trebleCode)
  );

  assign attLf  = attArr[0];
  assign attRf  = attArr[1];
  assign attLr  = attArr[2];
  assign attRr  = attArr[3];
  assign muteLf = muteArr[0];
  assign muteRf = muteArr[1];
  assign muteLr = muteArr[2];
  assign muteRr = muteArr[3];
endmodule

// File: rtl/audioCtlRegs_chk.sv
module audioCtlRegs_chk
  import audioCtlPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaPullLow,
  input ctlStrobes_t strobes,
  input logic [5:0]  volumeCode,
  input logic [4:0]  attLf,
  input logic [4:0]  attRf,
  input logic [4:0]  attLr,
  input logic [4:0]  attRr
);
  assert_pull_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> (!$past(sclIn) && !$past(sclIn, 2)));

  assert_pull_fall_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> (!$past(sclIn) && !$past(sclIn, 2)));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteStrobe |=> !strobes.byteStrobe);

  assert_strobe_not_in_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteStrobe |-> !sdaPullLow);

  assert_vol_needs_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.byteStrobe) |-> $stable(volumeCode));

  assert_one_speaker_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({attLf != $past(attLf), attRf != $past(attRf),
                attLr != $past(attLr), attRr != $past(attRr)}) <= 1);
endmodule

bind audioCtlRegs audioCtlRegs_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .strobes(strobes), .volumeCode(volumeCode),
  .attLf(attLf), .attRf(attRf), .attLr(attLr), .attRr(attRr)
);

// File: tb/audioCtlRegs_bench.sv
module audioCtlRegs_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow;
  logic sdaLine;
  logic [5:0] volumeCode;
  logic [4:0] attLf, attRf, attLr, attRr;
  logic muteLf, muteRf, muteLr, muteRr;
  logic [1:0] inputSel, inputGain;
  logic loudnessOn;
  logic [3:0] bassCode, trebleCode;

  assign sdaLine = sdaDrv & ~sdaPullLow;

  audioCtlRegs u_audioCtlRegs (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .volumeCode(volumeCode),
    .attLf(attLf), .attRf(attRf), .attLr(attLr), .attRr(attRr),
    .muteLf(muteLf), .muteRf(muteRf), .muteLr(muteLr), .muteRr(muteRr),
    .inputSel(inputSel), .inputGain(inputGain), .loudnessOn(loudnessOn),
    .bassCode(bassCode), .trebleCode(trebleCode)
  );

  localparam int Q = 6;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  logic [5:0] eVol;
  logic [4:0] eAtt [4];
  logic [1:0] eSel, eGain;
  logic eLoud;
  logic [3:0] eBass, eTreble;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string ctx);
    logic [4:0] act [4];
    logic [3:0] mAct;
    act[0] = attLf; act[1] = attRf; act[2] = attLr; act[3] = attRr;
    mAct = {muteRr, muteLr, muteRf, muteLf};
    chk(volumeCode == eVol, {ctx, " R5 volume"}, volumeCode, eVol);
    for (int s = 0; s < 4; s++) begin
      chk(act[s] == eAtt[s], {ctx, " R6 speaker"}, act[s], eAtt[s]);
      chk(mAct[s] == (eAtt[s] == 5'd31), {ctx, " R7 mute"}, mAct[s], eAtt[s] == 5'd31);
    end
    chk({inputGain, loudnessOn, inputSel} == {eGain, eLoud, eSel}, {ctx, " R8 switch"},
        {inputGain, loudnessOn, inputSel}, {eGain, eLoud, eSel});
    chk({bassCode, trebleCode} == {eBass, eTreble}, {ctx, " R9 tone"},
        {bassCode, trebleCode}, {eBass, eTreble});
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; tick(Q);
      sclDrv = 1'b1; tick(2 * Q);
      sclDrv = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    bit ack;
    eVol = 6'h3F;
    for (int s = 0; s < 4; s++) eAtt[s] = 5'h1F;
    eSel = 2'b00; eGain = 2'b11; eLoud = 1'b0; eBass = 4'hF; eTreble = 4'hF;

    tick(5); rstN = 1'b1; tick(5);
    checkAll("R1 reset");
    chk(sdaPullLow == 1'b0, "R1 pull released", sdaPullLow, 0);

    // R3: foreign address and read form are not acknowledged, data ignored
    busStart();
    sendByte(8'h8A, ack); chk(!ack, "R3 wrong addr ack", ack, 0);
    sendByte(8'h00, ack); chk(!ack, "R3 data after wrong addr", ack, 0);
    busStop(); checkAll("R3 after wrong addr");
    busStart();
    sendByte(8'h89, ack); chk(!ack, "R3 read addr ack", ack, 0);
    sendByte(8'h01, ack); chk(!ack, "R3 data after read addr", ack, 0);
    busStop(); checkAll("R3 after read addr");

    // R2/R4/R5: one long transfer sweeping every volume code
    busStart();
    sendByte(8'h88, ack); chk(ack, "R2 addr ack", ack, 1);
    for (int c = 63; c >= 0; c--) begin
      sendByte(8'(c), ack); chk(ack, "R4 data ack", ack, 1);
      eVol = 6'(c);
      checkAll("R5 sweep");
    end

    // R6/R7: every speaker, every code, in the same transfer
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 32; v++) begin
        sendByte(8'(128 + s * 32 + v), ack); chk(ack, "R4 data ack", ack, 1);
        eAtt[s] = 5'(v);
        checkAll("R6 sweep");
      end
    end
    sendByte(8'b1011_0100, ack);
    eAtt[1] = 5'b10100;
    checkAll("R6 right-front example");

    // R8: all switch codes
    for (int v = 0; v < 32; v++) begin
      sendByte(8'(64 + v), ack); chk(ack, "R4 data ack", ack, 1);
      eGain = 2'(v / 8); eLoud = ((v / 4) % 2) == 0; eSel = 2'(v % 4);
      checkAll("R8 sweep");
    end

    // R9: bass then treble codes
    for (int v = 0; v < 16; v++) begin
      sendByte(8'(96 + v), ack); eBass = 4'(v);
      checkAll("R9 bass sweep");
      sendByte(8'(112 + v), ack); eTreble = 4'(15 - v);
      if (v == 0) eTreble = 4'(0);
      eTreble = 4'(v);
      checkAll("R9 treble sweep");
    end
    busStop();
    chk(sdaPullLow == 1'b0, "R11 released after stop", sdaPullLow, 0);

    // R4: bytes after STOP without a new START are ignored
    sendByte(8'h05, ack); chk(!ack, "R4 no ack after stop", ack, 0);
    checkAll("R4 after stop");

    // R10: START in the middle of a byte discards the partial bits
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h05, ack); eVol = 6'h05;
    checkAll("R10 setup");
    sendBits(8'h00, 4);
    checkAll("R10 partial byte");
    busStart();
    sendByte(8'h88, ack); chk(ack, "R10 readdress ack", ack, 1);
    sendByte(8'b0010_0100, ack); eVol = 6'h24;
    checkAll("R10 after restart");
    busStop();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule